// File: doc/BRIEF.md
# Read-After-Write Stall and Bypass Controller

This block holds the dependency control for an in-order integer pipeline. One register-read stage feeds a chain of seven older stages. In pipeline order these are add, multiply, divide, branch, two memory stages and writeback. In every cycle the block compares the one or two source registers of the instruction in register read with the destinations of the instructions still in flight. From that comparison it picks one of three outcomes: the instruction holds in place, it reads the register file, or it takes a bypassed value. A bypassed value comes from the stage that has just computed it.

A result can be bypassed only from the end of the stage that computes it. Set, add and sub results come from the add stage, multiply results from the multiply stage and divide results from the divide stage. A value is not kept after that stage, and loads never bypass. A producer that has moved past the stage that computed its result therefore blocks its consumer until the producer has left writeback. This is because the register file cannot serve a read and a write to the same register in one cycle.

The decode logic ahead of this block turns instructions into operand-use flags. An immediate right operand, or a set or ret, clears the flag. A store's data register and a register address both count as sources. The stall output is combinational. The surrounding pipeline uses it to freeze the earlier stages and to send a bubble into the add stage.

Top module: `raw_hazard_ctrl`

## Requirements
- R1: An operand in use whose register matches no valid writing in-flight stage selects the register file (select code 0), and it causes no stall.
- R2: When the nearest producer of an operand sits in stage 0 (add) with kind code 0 (set/add/sub), the select is 1 and there is no stall.
- R3: When the nearest producer sits in stage 1 (multiply) with kind code 1, the select is 2. When it sits in stage 2 (divide) with kind code 2, the select is 3. Neither case stalls.
- R4: A nearest producer whose result is not produced by the stage it currently occupies causes a stall. Examples are kind 0 in stage 1, kind 1 in stage 0, or kind 2 in stage 3.
- R5: A nearest producer of kind code 3 (load) causes a stall in every stage from 0 to 6.
- R6: A nearest producer in stage 6 (writeback) causes a stall. Once it has left, the operand reads the register file.
- R7: Only the nearest producer counts, meaning the lowest stage index. If it cannot bypass, the instruction stalls even when an older producer could bypass.
- R8: An instruction with two sources proceeds only when both operands are ready in the same cycle. Each operand then carries its own select.
- R9: An operand whose use flag is 0 (immediate form, or no such source) creates no dependency, and its select is 0.
- R10: A stage whose valid bit or write-enable bit is 0 is never matched.
- R11: When register read holds no valid instruction, the stall is 0 and both selects are 0.
- R12: While the stall is 1, both selects are 0.
- R13: The stall and the selects follow their inputs within the same cycle, with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rr_valid_i | input | 1 | Register-read stage holds an instruction |
| rr_src_a_i | input | 4 | Left source register index |
| rr_use_a_i | input | 1 | Left source is read |
| rr_src_b_i | input | 4 | Right source register index |
| rr_use_b_i | input | 1 | Right source is a register (0 for immediate) |
| stg_valid_i | input | 7 | Per-stage valid, bit 0 = add stage, bit 6 = writeback |
| stg_wen_i | input | 7 | Per-stage writes a destination register |
| stg_dest_i | input | 28 | Per-stage destination index, 4 bits per stage, stage 0 lowest |
| stg_kind_i | input | 14 | Per-stage producer kind, 2 bits per stage: 0 set/add/sub, 1 mul, 2 div, 3 load |
| stall_o | output | 1 | Hold register read and earlier stages, inject a bubble |
| sel_a_o | output | 2 | Left operand source: 0 register file, 1 add, 2 mul, 3 div |
| sel_b_o | output | 2 | Right operand source, same coding |

## Verification
Every result is a pure function of the current inputs, so the stall and both selects are due in the same cycle as the stimulus that causes them, with no register on the way. The bench changes inputs only on the falling clock edge and samples 3 ns later, 1 ns before the next rising edge. It adds one early sample 1 ns after a change to show that no edge is needed. Multi-cycle cases, such as a producer moving from writeback to gone, are stepped one cycle at a time, and each step is checked in its own cycle.

// File: rtl/hzd_pkg.sv
package hzd_pkg;
  localparam int unsigned REG_COUNT = 16;
  localparam int unsigned REG_IDX_W = $clog2(REG_COUNT);

  typedef enum logic [1:0] {
    KIND_ALU  = 2'd0,
    KIND_MUL  = 2'd1,
    KIND_DIV  = 2'd2,
    KIND_LOAD = 2'd3
  } prod_kind_e;

  typedef enum logic [1:0] {
    SRC_RF  = 2'd0,
    SRC_ADD = 2'd1,
    SRC_MUL = 2'd2,
    SRC_DIV = 2'd3
  } opnd_sel_e;
endpackage

// File: rtl/hzd_stage_cmp.sv
// One in-flight stage seen from one source operand: does it write the
// register, and could it hand over the value at the end of this cycle?
module hzd_stage_cmp #(
  parameter int unsigned IDX_W     = hzd_pkg::REG_IDX_W,
  parameter int unsigned STAGE_POS = 0,
  parameter int unsigned ADD_POS   = 0,
  parameter int unsigned MUL_POS   = 1,
  parameter int unsigned DIV_POS   = 2
) (
  input  logic             valid_i,
  input  logic             wen_i,
  input  logic [IDX_W-1:0] dest_i,
  input  logic [1:0]       kind_i,
  input  logic [IDX_W-1:0] src_i,
  output logic             hit_o,
  output logic             fwd_ok_o,
  output logic [1:0]       fwd_sel_o
);
  import hzd_pkg::*;

  always_comb begin
    hit_o     = valid_i && wen_i && (dest_i == src_i);
    fwd_ok_o  = 1'b0;
    fwd_sel_o = SRC_RF;
    // A value exists on a bypass path only in the stage that computes it.
    if (STAGE_POS == ADD_POS && kind_i == KIND_ALU) begin
      fwd_ok_o  = 1'b1;
      fwd_sel_o = SRC_ADD;
    end
    if (STAGE_POS == MUL_POS && kind_i == KIND_MUL) begin
      fwd_ok_o  = 1'b1;
      fwd_sel_o = SRC_MUL;
    end
    if (STAGE_POS == DIV_POS && kind_i == KIND_DIV) begin
      fwd_ok_o  = 1'b1;
      fwd_sel_o = SRC_DIV;
    end
  end

  always_comb begin
    if (fwd_ok_o) begin
      AST_FWD_KIND_MATCH: assert (kind_i != KIND_LOAD)
        else $error("load result offered for bypass"); // R5
    end
  end
endmodule

// File: rtl/hzd_src_resolve.sv
// Resolves one source operand against every in-flight stage, nearest first.
module hzd_src_resolve #(
  parameter int unsigned IDX_W      = hzd_pkg::REG_IDX_W,
  parameter int unsigned NUM_STAGES = 7,
  parameter int unsigned ADD_POS    = 0,
  parameter int unsigned MUL_POS    = 1,
  parameter int unsigned DIV_POS    = 2
) (
  input  logic                        use_i,
  input  logic [IDX_W-1:0]            src_i,
  input  logic [NUM_STAGES-1:0]       stg_valid_i,
  input  logic [NUM_STAGES-1:0]       stg_wen_i,
  input  logic [NUM_STAGES*IDX_W-1:0] stg_dest_i,
  input  logic [NUM_STAGES*2-1:0]     stg_kind_i,
  output logic                        ready_o,
  output logic [1:0]                  sel_o
);
  import hzd_pkg::*;

  logic [NUM_STAGES-1:0] hit;
  logic [NUM_STAGES-1:0] fwd_ok;
  logic [1:0]            fwd_sel [NUM_STAGES];

  for (genvar g = 0; g < NUM_STAGES; g++) begin : g_stage
    hzd_stage_cmp #(
      .IDX_W    (IDX_W),
      .STAGE_POS(g),
      .ADD_POS  (ADD_POS),
      .MUL_POS  (MUL_POS),
      .DIV_POS  (DIV_POS)
    ) u_cmp (
      .valid_i  (stg_valid_i[g]),
      .wen_i    (stg_wen_i[g]),
      .dest_i   (stg_dest_i[g*IDX_W +: IDX_W]),
      .kind_i   (stg_kind_i[g*2 +: 2]),
      .src_i    (src_i),
      .hit_o    (hit[g]),
      .fwd_ok_o (fwd_ok[g]),
      .fwd_sel_o(fwd_sel[g])
    );
  end

  always_comb begin
    logic found;
    found   = 1'b0;
    ready_o = 1'b1;
    sel_o   = SRC_RF;
    for (int i = 0; i < NUM_STAGES; i++) begin
      if (!found && hit[i]) begin
        found   = 1'b1;
        ready_o = fwd_ok[i];
        sel_o   = fwd_ok[i] ? fwd_sel[i] : SRC_RF;
      end
    end
    if (!use_i) begin
      ready_o = 1'b1;
      sel_o   = SRC_RF;
    end
  end

  always_comb begin
    if (use_i && sel_o != SRC_RF) begin
      AST_BYPASS_NEEDS_HIT: assert (|hit)
        else $error("bypass chosen with no matching producer"); // R1
    end
    if (!use_i) begin
      AST_UNUSED_READY: assert (ready_o && sel_o == SRC_RF)
        else $error("unused operand created a dependency"); // R9
    end
  end
endmodule

// File: rtl/raw_hazard_ctrl.sv
module raw_hazard_ctrl #(
  parameter int unsigned IDX_W      = hzd_pkg::REG_IDX_W,
  parameter int unsigned NUM_STAGES = 7,
  parameter int unsigned ADD_POS    = 0,
  parameter int unsigned MUL_POS    = 1,
  parameter int unsigned DIV_POS    = 2
) (
  input  logic                        rr_valid_i,
  input  logic [IDX_W-1:0]            rr_src_a_i,
  input  logic                        rr_use_a_i,
  input  logic [IDX_W-1:0]            rr_src_b_i,
  input  logic                        rr_use_b_i,
  input  logic [NUM_STAGES-1:0]       stg_valid_i,
  input  logic [NUM_STAGES-1:0]       stg_wen_i,
  input  logic [NUM_STAGES*IDX_W-1:0] stg_dest_i,
  input  logic [NUM_STAGES*2-1:0]     stg_kind_i,
  output logic                        stall_o,
  output logic [1:0]                  sel_a_o,
  output logic [1:0]                  sel_b_o
);
  import hzd_pkg::*;

  localparam int unsigned LAST_POS = NUM_STAGES - 1;
  localparam int unsigned NUM_OPND = 2;

  logic [NUM_OPND-1:0]  opnd_use;
  logic [IDX_W-1:0]     opnd_src [NUM_OPND];
  logic [NUM_OPND-1:0]  opnd_ready;
  logic [1:0]           opnd_sel [NUM_OPND];

  assign opnd_use    = {rr_use_b_i, rr_use_a_i};
  assign opnd_src[0] = rr_src_a_i;
  assign opnd_src[1] = rr_src_b_i;

  for (genvar o = 0; o < NUM_OPND; o++) begin : g_opnd
    hzd_src_resolve #(
      .IDX_W     (IDX_W),
      .NUM_STAGES(NUM_STAGES),
      .ADD_POS   (ADD_POS),
      .MUL_POS   (MUL_POS),
      .DIV_POS   (DIV_POS)
    ) u_res (
      .use_i      (opnd_use[o]),
      .src_i      (opnd_src[o]),
      .stg_valid_i(stg_valid_i),
      .stg_wen_i  (stg_wen_i),
      .stg_dest_i (stg_dest_i),
      .stg_kind_i (stg_kind_i),
      .ready_o    (opnd_ready[o]),
      .sel_o      (opnd_sel[o])
    );
  end

  // Both operands must be ready together; a bypassed value is not held.
  always_comb begin
    stall_o = rr_valid_i && !(&opnd_ready);
    sel_a_o = SRC_RF;
    sel_b_o = SRC_RF;
    if (rr_valid_i && !stall_o) begin
      sel_a_o = opnd_sel[0];
      sel_b_o = opnd_sel[1];
    end
  end

  always_comb begin
    if (!rr_valid_i) begin
      AST_IDLE_QUIET: assert (!stall_o && sel_a_o == SRC_RF && sel_b_o == SRC_RF)
        else $error("activity with empty register-read stage"); // R11
    end
    if (stall_o) begin
      AST_STALL_NO_SEL: assert (sel_a_o == SRC_RF && sel_b_o == SRC_RF)
        else $error("bypass select during stall"); // R12
    end
    if (rr_valid_i && rr_use_a_i && stg_valid_i[LAST_POS] && stg_wen_i[LAST_POS]
        && stg_dest_i[LAST_POS*IDX_W +: IDX_W] == rr_src_a_i) begin
      AST_NO_WB_SAME_READ: assert (stall_o || sel_a_o != SRC_RF)
        else $error("read of register under writeback"); // R6
    end
    if (sel_a_o == SRC_ADD) begin
      AST_ADD_SEL_SRC: assert (stg_valid_i[ADD_POS] && stg_wen_i[ADD_POS]
        && stg_dest_i[ADD_POS*IDX_W +: IDX_W] == rr_src_a_i
        && stg_kind_i[ADD_POS*2 +: 2] == KIND_ALU)
        else $error("add bypass without add-stage producer"); // R2
    end
  end
endmodule

// File: tb/raw_hazard_ctrl_bench.sv
module raw_hazard_ctrl_bench;
  localparam int NS = 7;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic            rr_valid, use_a, use_b;
  logic [3:0]      src_a, src_b;
  logic            bv [NS];
  logic            bw [NS];
  logic [3:0]      bd [NS];
  logic [1:0]      bk [NS];
  logic [NS-1:0]   stg_valid, stg_wen;
  logic [NS*4-1:0] stg_dest;
  logic [NS*2-1:0] stg_kind;
  logic            stall;
  logic [1:0]      sel_a, sel_b;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always_comb begin
    for (int s = 0; s < NS; s++) begin
      stg_valid[s]        = bv[s];
      stg_wen[s]          = bw[s];
      stg_dest[s*4 +: 4]  = bd[s];
      stg_kind[s*2 +: 2]  = bk[s];
    end
  end

  raw_hazard_ctrl u_raw_hazard_ctrl (
    .rr_valid_i (rr_valid),
    .rr_src_a_i (src_a),
    .rr_use_a_i (use_a),
    .rr_src_b_i (src_b),
    .rr_use_b_i (use_b),
    .stg_valid_i(stg_valid),
    .stg_wen_i  (stg_wen),
    .stg_dest_i (stg_dest),
    .stg_kind_i (stg_kind),
    .stall_o    (stall),
    .sel_a_o    (sel_a),
    .sel_b_o    (sel_b)
  );

  task automatic clear_all();
    rr_valid = 1'b0; use_a = 1'b0; use_b = 1'b0; src_a = '0; src_b = '0;
    for (int s = 0; s < NS; s++) begin
      bv[s] = 1'b0; bw[s] = 1'b0; bd[s] = '0; bk[s] = '0;
    end
  endtask

  task automatic put(input int s, input logic [3:0] d, input logic [1:0] k);
    bv[s] = 1'b1; bw[s] = 1'b1; bd[s] = d; bk[s] = k;
  endtask

  task automatic rr(input logic [3:0] a, input logic ua, input logic [3:0] b, input logic ub);
    rr_valid = 1'b1; src_a = a; use_a = ua; src_b = b; use_b = ub;
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic check(input string req, input logic es, input logic [1:0] ea, input logic [1:0] eb);
    checks++;
    if (stall !== es || sel_a !== ea || sel_b !== eb) begin
      errors++;
      $display("FAIL %s: stall/sel_a/sel_b actual %b/%0d/%0d expected %b/%0d/%0d",
               req, stall, sel_a, sel_b, es, ea, eb);
    end
  endtask

  // Sample 1 ns before the rising edge that follows the falling-edge drive.
  task automatic settle_check(input string req, input logic es, input logic [1:0] ea, input logic [1:0] eb);
    #3;
    check(req, es, ea, eb);
  endtask

  // Reference model built from the requirement text.
  function automatic void model(input logic u, input logic [3:0] src,
                                output logic rdy, output logic [1:0] sel);
    int near;
    rdy = 1'b1; sel = 2'd0; near = -1;
    if (!u) return;
    for (int s = NS - 1; s >= 0; s--)
      if (bv[s] && bw[s] && bd[s] == src) near = s;
    if (near < 0) return;
    if      (near == 0 && bk[near] == 2'd0) sel = 2'd1;
    else if (near == 1 && bk[near] == 2'd1) sel = 2'd2;
    else if (near == 2 && bk[near] == 2'd2) sel = 2'd3;
    else rdy = 1'b0;
  endfunction

  task automatic t_idle();
    step(); clear_all();
    settle_check("R11 empty", 1'b0, 2'd0, 2'd0);
    step(); put(0, 4'd3, 2'd3); src_a = 4'd3; use_a = 1'b1;
    settle_check("R11 invalid rr", 1'b0, 2'd0, 2'd0);
  endtask

  task automatic t_no_dep();
    step(); clear_all(); rr(4'd3, 1'b1, 4'd5, 1'b1);
    put(0, 4'd7, 2'd0); put(4, 4'd9, 2'd3);
    settle_check("R1 no match", 1'b0, 2'd0, 2'd0);
    step(); bv[1] = 1'b0; bw[1] = 1'b1; bd[1] = 4'd3; bk[1] = 2'd0;
    bv[5] = 1'b1; bw[5] = 1'b0; bd[5] = 4'd5; bk[5] = 2'd3;
    settle_check("R10 invalid or non-writing", 1'b0, 2'd0, 2'd0);
  endtask

  task automatic t_add();
    step(); clear_all(); rr(4'd3, 1'b1, 4'd5, 1'b1); put(0, 4'd3, 2'd0);
    settle_check("R2 add bypass a", 1'b0, 2'd1, 2'd0);
    step(); put(0, 4'd5, 2'd0);
    settle_check("R2 add bypass b", 1'b0, 2'd0, 2'd1);
  endtask

  task automatic t_mul_div();
    step(); clear_all(); rr(4'd3, 1'b1, 4'd5, 1'b1);
    put(1, 4'd3, 2'd1); put(2, 4'd5, 2'd2);
    settle_check("R3 mul+div", 1'b0, 2'd2, 2'd3);
  endtask

  task automatic t_wrong_stage();
    step(); clear_all(); rr(4'd3, 1'b1, 4'd0, 1'b0); put(1, 4'd3, 2'd0);
    settle_check("R4 alu in mul stage", 1'b1, 2'd0, 2'd0);
    step(); clear_all(); rr(4'd3, 1'b1, 4'd0, 1'b0); put(0, 4'd3, 2'd1);
    settle_check("R4 mul in add stage", 1'b1, 2'd0, 2'd0);
    step(); clear_all(); rr(4'd3, 1'b1, 4'd0, 1'b0); put(3, 4'd3, 2'd2);
    settle_check("R4 div in branch stage", 1'b1, 2'd0, 2'd0);
  endtask

  task automatic t_load();
    for (int s = 0; s < NS; s++) begin
      step(); clear_all(); rr(4'd8, 1'b1, 4'd0, 1'b0); put(s, 4'd8, 2'd3);
      settle_check("R5 load producer", 1'b1, 2'd0, 2'd0);
    end
  endtask

  task automatic t_wb();
    step(); clear_all(); rr(4'd4, 1'b1, 4'd0, 1'b0); put(5, 4'd4, 2'd0);
    settle_check("R6 in mem2", 1'b1, 2'd0, 2'd0);
    step(); bv[5] = 1'b0; put(6, 4'd4, 2'd0);
    settle_check("R6 in writeback", 1'b1, 2'd0, 2'd0);
    step(); bv[6] = 1'b0;
    settle_check("R6 after writeback", 1'b0, 2'd0, 2'd0);
  endtask

  task automatic t_youngest();
    step(); clear_all(); rr(4'd3, 1'b1, 4'd0, 1'b0);
    put(1, 4'd3, 2'd0); put(2, 4'd3, 2'd2);
    settle_check("R7 near blocks", 1'b1, 2'd0, 2'd0);
    step(); clear_all(); rr(4'd3, 1'b1, 4'd0, 1'b0);
    put(0, 4'd3, 2'd0); put(1, 4'd3, 2'd1); put(4, 4'd3, 2'd3);
    settle_check("R7 near bypasses", 1'b0, 2'd1, 2'd0);
  endtask

  task automatic t_both();
    step(); clear_all(); rr(4'd3, 1'b1, 4'd5, 1'b1);
    put(0, 4'd3, 2'd0); put(4, 4'd5, 2'd3);
    settle_check("R8 R12 one not ready", 1'b1, 2'd0, 2'd0);
    step(); clear_all(); rr(4'd3, 1'b1, 4'd3, 1'b1); put(0, 4'd3, 2'd0);
    settle_check("R8 same producer", 1'b0, 2'd1, 2'd1);
  endtask

  task automatic t_unused();
    step(); clear_all(); rr(4'd2, 1'b1, 4'd5, 1'b0); put(0, 4'd5, 2'd3);
    settle_check("R9 immediate b", 1'b0, 2'd0, 2'd0);
    step(); clear_all(); rr(4'd5, 1'b0, 4'd5, 1'b0); put(0, 4'd5, 2'd0);
    settle_check("R9 no sources", 1'b0, 2'd0, 2'd0);
  endtask

  task automatic t_comb();
    step(); clear_all(); rr(4'd6, 1'b1, 4'd0, 1'b0); put(3, 4'd6, 2'd0);
    #1; check("R13 early stall", 1'b1, 2'd0, 2'd0);
    #1; bv[3] = 1'b0; put(2, 4'd6, 2'd2);
    #1; check("R13 early bypass", 1'b0, 2'd3, 2'd0);
  endtask

  task automatic t_sweep();
    logic [15:0] lf = 16'hACE1;
    for (int n = 0; n < 400; n++) begin
      logic ra, rb; logic [1:0] ea, eb; logic es;
      step(); clear_all();
      for (int s = 0; s < NS; s++) begin
        lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
        bv[s] = lf[0]; bw[s] = lf[1] | lf[2]; bd[s] = {2'b00, lf[4:3]}; bk[s] = lf[6:5];
      end
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      rr(.a({2'b00, lf[1:0]}), .ua(lf[2] | lf[3]), .b({2'b00, lf[5:4]}), .ub(lf[6]));
      rr_valid = lf[7] | lf[8] | lf[9];
      model(use_a, src_a, ra, ea);
      model(use_b, src_b, rb, eb);
      es = rr_valid && !(ra && rb);
      if (es || !rr_valid) begin ea = 2'd0; eb = 2'd0; end
      settle_check("R7 R8 sweep", es, ea, eb);
    end
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: run did not complete");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    clear_all();
    t_idle();
    t_no_dep();
    t_add();
    t_mul_div();
    t_wrong_stage();
    t_load();
    t_wb();
    t_youngest();
    t_both();
    t_unused();
    t_comb();
    t_sweep();
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule